// File: doc/BRIEF.md
# Interrupt Level Encoder with Acknowledge

This block gathers active-low interrupt request lines from many sources and presents one encoded priority level to the CPU on three active-low lines. The sources are grouped by level. Display sync, display-list and copy-engine completion share level 2. Audio channels use level 4. The serial port uses level 5. The two timer/port devices share level 6. An expansion card may drive a line in either the level 2 group or the level 6 group. Every group is a bank of open request lines, and any low line in a bank makes that level pending.

When the CPU enters an interrupt-acknowledge cycle, it drives function code 111 and asserts its address strobe. Address bits 3:1 then carry the level being acknowledged. A small state machine samples this. If the named level is one this block serves and it has a pending request, the machine pulses that level's acknowledge strobe toward the source and supplies the level's autovector number. Otherwise it raises a spurious-interrupt flag and supplies the spurious vector. Interrupt latching inside the peripherals is outside this block.

The state machine has three states:
- `ST_IDLE` watches the bus.
- `ST_GRANT` drives one acknowledge strobe and a valid autovector.
- `ST_SPUR` drives the spurious flag and the spurious vector.

It has five named transitions:
- `IDLE->GRANT`: an acknowledge cycle names a served level that is pending.
- `IDLE->SPUR`: an acknowledge cycle names an unserved level, or a level that is not pending.
- `GRANT->IDLE`: the strobe is released.
- `SPUR->IDLE`: the strobe is released.
- `IDLE->IDLE`: no acknowledge cycle is under way.

Top module: `ipl_merge_ack`

## Requirements
- R1: A low line in a group makes that group's level pending. The groups are: `lvl2_req_n` for level 2 (bit 3 is the expansion line), `lvl4_req_n` for level 4, `lvl5_req_n` for level 5, and `lvl6_req_n` for level 6 (bit 2 is the expansion line).
- R2: When several levels are pending at once, `ipl_n` shows only the highest of them. The order is 6 > 5 > 4 > 2.
- R3: `ipl_n` is the bitwise inverse of the highest pending level: 101 for level 2, 011 for level 4, 010 for level 5, 001 for level 6. It is registered, so it follows the request lines one clock after they change.
- R4: When no request line is low, `ipl_n` reads 111.
- R5: An acknowledge cycle is recognised only when `fc` is 111 and `as_n` is low at a clock edge. Any other function code, or a high strobe, leaves `ack_n` at 1111 and `vec_valid` low.
- R6: An acknowledge cycle for a served level that is pending moves the machine to `ST_GRANT` on that edge. In that state the level's bit of `ack_n` goes low; the bit order is bit0 = level 2, bit1 = level 4, bit2 = level 5, bit3 = level 6. `vec` shows 24 plus the level, which gives 26, 28, 29 or 30; these are the vectors at addresses 0x68, 0x70, 0x74 and 0x78. `vec_valid` is high and `spurious` is low.
- R7: An acknowledge cycle for a level that is not pending, or for a level this block does not serve (1, 3 or 7), moves the machine to `ST_SPUR`. In that state `spurious` is high, `vec` is 24, `vec_valid` is high and `ack_n` stays 1111.
- R8: The outputs of `ST_GRANT` and `ST_SPUR` hold for as long as `as_n` stays low. On the first edge that samples `as_n` high, the machine returns to `ST_IDLE`, and `ack_n`, `vec_valid` and `spurious` drop.
- R9: During reset, `ipl_n` is 111, `ack_n` is 1111, and `vec_valid` and `spurious` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl2_req_n | input | L2_SRC | Level 2 request lines, active low |
| lvl4_req_n | input | L4_SRC | Level 4 request lines, active low |
| lvl5_req_n | input | L5_SRC | Level 5 request lines, active low |
| lvl6_req_n | input | L6_SRC | Level 6 request lines, active low |
| fc | input | 3 | CPU function code |
| as_n | input | 1 | CPU address strobe, active low |
| ack_lvl | input | 3 | Address bits 3:1 during acknowledge |
| ipl_n | output | 3 | Encoded priority level, active low |
| ack_n | output | 4 | Per-level acknowledge strobes, active low |
| vec | output | 8 | Vector number |
| vec_valid | output | 1 | Vector byte is valid |
| spurious | output | 1 | Acknowledged level had no request |

## Verification
The bench builds the block with its default group widths: four level 2 lines, four level 4 lines, one level 5 line and three level 6 lines. These widths put the expansion line within reach both as the top bit of the level 2 bank and as the top bit of the level 6 bank, alongside the single-line serial group. A stimulus table walks mixed request patterns through the priority encoding. Directed acknowledge cycles then cover every served level, an unpending level, an unserved level, a wrong function code and a long-held strobe.

// File: rtl/ipl_pkg.sv
package ipl_pkg;

    localparam int SLOTS        = 4;
    localparam int AUTOVEC_BASE = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GRANT,
        ST_SPUR
    } ack_state_t;

    function automatic logic level_served(input logic [2:0] lvl);
        return (lvl == 3'd2) || (lvl == 3'd4) || (lvl == 3'd5) || (lvl == 3'd6);
    endfunction

    function automatic logic [1:0] slot_of(input logic [2:0] lvl);
        logic [1:0] s;
        case (lvl)
            3'd4:    s = 2'd1;
            3'd5:    s = 2'd2;
            3'd6:    s = 2'd3;
            default: s = 2'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ipl_src_merge.sv
module ipl_src_merge #(
    parameter int W = 1
) (
    input  logic [W-1:0] req_n,
    output logic         active
);
    always_comb begin
        active = ~(&req_n);
    end
endmodule

// File: rtl/ipl_prio_enc.sv
module ipl_prio_enc
    import ipl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] active,
    output logic [2:0]       ipl_n,
    output logic [SLOTS-1:0] pend_q
);
    logic [2:0] level_d;

    always_comb begin
        if (active[3])      level_d = 3'd6;
        else if (active[2]) level_d = 3'd5;
        else if (active[1]) level_d = 3'd4;
        else if (active[0]) level_d = 3'd2;
        else                level_d = 3'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ipl_n  <= 3'b111;
            pend_q <= '0;
        end else begin
            ipl_n  <= ~level_d;
            pend_q <= active;
        end
    end

    AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |=> (ipl_n == 3'b111)); // R4
    AST_TOP_LEVEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        active[3] |=> (ipl_n == 3'b001)); // R2
    AST_LEVEL2_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (active == 4'b0001) |=> (ipl_n == 3'b101)); // R1
endmodule

// File: rtl/ipl_ack_fsm.sv
module ipl_ack_fsm
    import ipl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       fc,
    input  logic             as_n,
    input  logic [2:0]       ack_lvl,
    input  logic [SLOTS-1:0] pend_q,
    output logic [SLOTS-1:0] ack_n,
    output logic [7:0]       vec,
    output logic             vec_valid,
    output logic             spurious
);
    ack_state_t state_q, state_d;
    logic [2:0] lvl_q;
    logic       ack_cycle;
    logic       hit;

    always_comb begin
        ack_cycle = (fc == 3'b111) && !as_n;
        hit       = level_served(ack_lvl) && pend_q[slot_of(ack_lvl)];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ack_cycle) state_d = hit ? ST_GRANT : ST_SPUR;
            end
            ST_GRANT: begin
                if (as_n) state_d = ST_IDLE;
            end
            ST_SPUR: begin
                if (as_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= 3'd0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && ack_cycle) lvl_q <= ack_lvl;
        end
    end

    always_comb begin
        ack_n     = '1;
        vec       = 8'd0;
        vec_valid = 1'b0;
        spurious  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_GRANT: begin
                ack_n[slot_of(lvl_q)] = 1'b0;
                vec       = 8'(AUTOVEC_BASE) + {5'd0, lvl_q};
                vec_valid = 1'b1;
            end
            ST_SPUR: begin
                vec       = 8'(AUTOVEC_BASE);
                vec_valid = 1'b1;
                spurious  = 1'b1;
            end
            default: begin
            end
        endcase
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ack_n) <= 1); // R6
    AST_STROBE_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_n != '1) |-> $past(!as_n)); // R5
    AST_SPUR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        spurious |-> (ack_n == '1)); // R7
    AST_SPUR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        spurious |-> (vec == 8'd24)); // R7
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && as_n) |=> (ack_n == '1 && !vec_valid && !spurious)); // R8
endmodule

// File: rtl/ipl_merge_ack.sv
module ipl_merge_ack
    import ipl_pkg::*;
#(
    parameter int L2_SRC = 4,
    parameter int L4_SRC = 4,
    parameter int L5_SRC = 1,
    parameter int L6_SRC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [L2_SRC-1:0] lvl2_req_n,
    input  logic [L4_SRC-1:0] lvl4_req_n,
    input  logic [L5_SRC-1:0] lvl5_req_n,
    input  logic [L6_SRC-1:0] lvl6_req_n,
    input  logic [2:0]        fc,
    input  logic              as_n,
    input  logic [2:0]        ack_lvl,
    output logic [2:0]        ipl_n,
    output logic [3:0]        ack_n,
    output logic [7:0]        vec,
    output logic              vec_valid,
    output logic              spurious
);
    logic [SLOTS-1:0] active;
    logic [SLOTS-1:0] pend_q;

    ipl_src_merge #(.W(L2_SRC)) u_m2 (.req_n(lvl2_req_n), .active(active[0]));
    ipl_src_merge #(.W(L4_SRC)) u_m4 (.req_n(lvl4_req_n), .active(active[1]));
    ipl_src_merge #(.W(L5_SRC)) u_m5 (.req_n(lvl5_req_n), .active(active[2]));
    ipl_src_merge #(.W(L6_SRC)) u_m6 (.req_n(lvl6_req_n), .active(active[3]));

    ipl_prio_enc u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .ipl_n  (ipl_n),
        .pend_q (pend_q)
    );

    ipl_ack_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fc        (fc),
        .as_n      (as_n),
        .ack_lvl   (ack_lvl),
        .pend_q    (pend_q),
        .ack_n     (ack_n),
        .vec       (vec),
        .vec_valid (vec_valid),
        .spurious  (spurious)
    );
endmodule

// File: tb/sim_ipl_merge_ack.sv
module sim_ipl_merge_ack;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] l2 = 4'hF;
    logic [3:0] l4 = 4'hF;
    logic [0:0] l5 = 1'b1;
    logic [2:0] l6 = 3'b111;
    logic [2:0] fc = 3'b000;
    logic       as_n = 1'b1;
    logic [2:0] alvl = 3'd0;
    logic [2:0] ipl_n;
    logic [3:0] ack_n;
    logic [7:0] vec;
    logic       vec_valid;
    logic       spurious;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ipl_merge_ack u0 (
        .clk(clk), .rst_n(rst_n),
        .lvl2_req_n(l2), .lvl4_req_n(l4), .lvl5_req_n(l5), .lvl6_req_n(l6),
        .fc(fc), .as_n(as_n), .ack_lvl(alvl),
        .ipl_n(ipl_n), .ack_n(ack_n), .vec(vec),
        .vec_valid(vec_valid), .spurious(spurious)
    );

    // {l2[3:0], l4[3:0], l5, l6[2:0], expected ipl_n[2:0]}
    localparam logic [14:0] TBL [12] = '{
        {4'b1111, 4'b1111, 1'b1, 3'b111, 3'b111}, // R4
        {4'b1110, 4'b1111, 1'b1, 3'b111, 3'b101}, // R1
        {4'b0111, 4'b1111, 1'b1, 3'b111, 3'b101}, // R1 expansion on level 2
        {4'b1111, 4'b1011, 1'b1, 3'b111, 3'b011}, // R3
        {4'b1101, 4'b0111, 1'b1, 3'b111, 3'b011}, // R2
        {4'b1111, 4'b1111, 1'b0, 3'b111, 3'b010}, // R3
        {4'b1111, 4'b0000, 1'b0, 3'b111, 3'b010}, // R2
        {4'b1111, 4'b1111, 1'b1, 3'b110, 3'b001}, // R3
        {4'b0000, 4'b1111, 1'b1, 3'b011, 3'b001}, // R1 expansion on level 6
        {4'b0000, 4'b0000, 1'b0, 3'b000, 3'b001}, // R2
        {4'b1011, 4'b1111, 1'b1, 3'b111, 3'b101}, // R1
        {4'b1111, 4'b1111, 1'b1, 3'b111, 3'b111}  // R4
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ack_cycle(input logic [2:0] code, input logic [2:0] lvl);
        fc = code; alvl = lvl; as_n = 1'b0;
        step();
    endtask

    task automatic release_bus();
        as_n = 1'b1;
        step();
        fc = 3'b000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 ipl", 32'(ipl_n), 32'h7);
        chk("R9 ack", 32'(ack_n), 32'hF);
        chk("R9 vv", 32'(vec_valid), 0);
        chk("R9 spur", 32'(spurious), 0);
        rst_n = 1'b1;
        step();

        for (int i = 0; i < 12; i++) begin
            {l2, l4, l5, l6} = TBL[i][14:3];
            step();
            chk($sformatf("R1/R2/R3/R4 row %0d", i), 32'(ipl_n), 32'(TBL[i][2:0]));
        end

        // R3 one-cycle latency: before the edge the old value remains
        l6 = 3'b101;
        chk("R3 before edge", 32'(ipl_n), 32'h7);
        step();
        chk("R3 after edge", 32'(ipl_n), 32'h1);
        l6 = 3'b111;
        l4 = 4'b1110;
        l2 = 4'b1110;
        step();

        // R5 wrong function code
        ack_cycle(3'b110, 3'd4);
        chk("R5 fc110 ack", 32'(ack_n), 32'hF);
        chk("R5 fc110 vv", 32'(vec_valid), 0);
        release_bus();
        // R5 strobe high
        fc = 3'b111; alvl = 3'd4; as_n = 1'b1;
        step();
        chk("R5 as high ack", 32'(ack_n), 32'hF);
        chk("R5 as high vv", 32'(vec_valid), 0);
        fc = 3'b000;
        step();

        // R6 level 4 grant
        ack_cycle(3'b111, 3'd4);
        chk("R6 l4 ack", 32'(ack_n), 32'hD);
        chk("R6 l4 vec", 32'(vec), 28);
        chk("R6 l4 vv", 32'(vec_valid), 1);
        chk("R6 l4 spur", 32'(spurious), 0);
        // R8 hold
        step();
        chk("R8 hold ack", 32'(ack_n), 32'hD);
        chk("R8 hold vec", 32'(vec), 28);
        release_bus();
        chk("R8 release ack", 32'(ack_n), 32'hF);
        chk("R8 release vv", 32'(vec_valid), 0);

        // R6 level 2 grant while level 4 is also pending
        ack_cycle(3'b111, 3'd2);
        chk("R6 l2 ack", 32'(ack_n), 32'hE);
        chk("R6 l2 vec", 32'(vec), 26);
        release_bus();

        // R7 level 5 not pending
        ack_cycle(3'b111, 3'd5);
        chk("R7 l5 spur", 32'(spurious), 1);
        chk("R7 l5 vec", 32'(vec), 24);
        chk("R7 l5 ack", 32'(ack_n), 32'hF);
        chk("R7 l5 vv", 32'(vec_valid), 1);
        release_bus();
        chk("R8 spur release", 32'(spurious), 0);

        // R7 unserved level 3
        ack_cycle(3'b111, 3'd3);
        chk("R7 l3 spur", 32'(spurious), 1);
        chk("R7 l3 ack", 32'(ack_n), 32'hF);
        release_bus();

        // R6 level 5 and level 6 grants
        l5 = 1'b0; l6 = 3'b011;
        step();
        ack_cycle(3'b111, 3'd5);
        chk("R6 l5 ack", 32'(ack_n), 32'hB);
        chk("R6 l5 vec", 32'(vec), 29);
        release_bus();
        ack_cycle(3'b111, 3'd6);
        chk("R6 l6 ack", 32'(ack_n), 32'h7);
        chk("R6 l6 vec", 32'(vec), 30);
        chk("R6 l6 spur", 32'(spurious), 0);
        release_bus();
        chk("R8 l6 release", 32'(ack_n), 32'hF);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule